// File: doc/BRIEF.md
# Nonvolatile SRAM Power Sequencer

This block runs a nonvolatile SRAM through power-up, brown-out and power-down. It uses two digitised supply-monitor flags. `aboveSwitch` says the supply is above the upper switching threshold, which sits somewhere between 4.0 V and 4.5 V. `aboveReset` says the supply is above the 3.6 V reset threshold. Both flags are resynchronised to the block clock. The analog comparators and the nonvolatile cells are outside the block.

From these two flags the block makes three decisions:

- **Recall.** It launches an automatic recall on the first supply rise after reset. It launches another one after any brown-out that took the supply below the reset threshold. It launches none after a shallow dip that stayed above that threshold. A latched "needs recall" flag holds this history.
- **Store blocking.** It blocks every store while the supply is below the switching threshold.
- **Access.** After each recall it keeps the SRAM unavailable for a hold-off time, counted in clock cycles.

Top module: `nvsram_power_seq`

## Requirements
- R1: Each supply flag passes through a `SYNC_STAGES`-deep flop chain (default 2). A change on an input pin becomes visible to the logic after that many rising clock edges.
- R2: After reset the block needs a recall. When both synchronised flags are first high, `recallStart` pulses high for exactly one cycle, one edge after the synchronised flags rise.
- R3: `storeInhibit` is 1 whenever the synchronised `aboveSwitch` is 0, and 0 otherwise.
- R4: A dip in which `aboveSwitch` goes low while `aboveReset` stays high produces no `recallStart` pulse when `aboveSwitch` returns high.
- R5: Once the synchronised `aboveReset` has been 0, the block needs a recall. A later return of both flags high produces exactly one `recallStart` pulse. Launching that recall clears the need.
- R6: `holdoffBusy` rises on the same edge as `recallStart` and stays 1 for exactly `HOLDOFF` cycles.
- R7: `sramReady` is 1 only when the synchronised `aboveSwitch` is 1 and `holdoffBusy` is 0.
- R8: While `rstN` is low the outputs are `recallStart`=0, `storeInhibit`=1, `sramReady`=0 and `holdoffBusy`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low asynchronous reset |
| aboveSwitch | input | 1 | Supply above the switching threshold (asynchronous) |
| aboveReset | input | 1 | Supply above the reset threshold (asynchronous) |
| recallStart | output | 1 | One-cycle strobe that launches a recall |
| storeInhibit | output | 1 | Blocks nonvolatile stores |
| sramReady | output | 1 | SRAM may be accessed |
| holdoffBusy | output | 1 | Recall hold-off timer is running |

## Verification
The bench builds the block with `HOLDOFF` = 8 and `SYNC_STAGES` = 2. This keeps the whole hold-off window short enough to count edge by edge. It lets the bench sample the exact cycle where `sramReady` rises, and the exact cycle before it. With these values, one vector table can cover a cold rise, a shallow dip, a deep dip and a partial recovery from that deep dip. Each is checked at the cycle predicted from the synchroniser depth.

// File: rtl/nvsram_power_seq_pkg.sv
package nvsram_power_seq_pkg;

  // Strobes issued by the control FSM to the datapath.
  typedef struct packed {
    logic loadTimer;
  } seqStrobe_t;

endpackage

// File: rtl/nvsram_power_seq_dp.sv
module nvsram_power_seq_dp
  import nvsram_power_seq_pkg::*;
#(
  parameter int HOLDOFF     = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       aboveSwitch,
  input  logic       aboveReset,
  input  seqStrobe_t strobe,
  output logic       switchSync,
  output logic       resetSync,
  output logic       timerBusy
);

  localparam int CW = $clog2(HOLDOFF + 1);
  localparam logic [CW-1:0] LOADV = CW'(HOLDOFF);

  logic [SYNC_STAGES-1:0] swChain;
  logic [SYNC_STAGES-1:0] rsChain;

  generate
    if (SYNC_STAGES == 1) begin : gSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          swChain <= '0;
          rsChain <= '0;
        end else begin
          swChain <= aboveSwitch;
          rsChain <= aboveReset;
        end
      end
    end else begin : gMulti
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          swChain <= '0;
          rsChain <= '0;
        end else begin
          swChain <= {swChain[SYNC_STAGES-2:0], aboveSwitch};
          rsChain <= {rsChain[SYNC_STAGES-2:0], aboveReset};
        end
      end
    end
  endgenerate

  assign switchSync = swChain[SYNC_STAGES-1];
  assign resetSync  = rsChain[SYNC_STAGES-1];

  logic [CW-1:0] holdCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strobe.loadTimer) begin
      holdCnt <= LOADV;
    end else if (holdCnt != '0) begin
      holdCnt <= holdCnt - 1'b1;
    end
  end

  assign timerBusy = (holdCnt != '0);

  AST_TIMER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadTimer |=> timerBusy); // R6
  AST_TIMER_NO_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (!timerBusy && !strobe.loadTimer) |=> !timerBusy); // R6

endmodule

// File: rtl/nvsram_power_seq_ctrl.sv
module nvsram_power_seq_ctrl
  import nvsram_power_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       switchSync,
  input  logic       resetSync,
  input  logic       timerBusy,
  output seqStrobe_t strobe,
  output logic       recallStart,
  output logic       storeInhibit,
  output logic       sramReady
);

  logic needRecall;
  logic launch;

  assign launch = needRecall && switchSync && resetSync;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      needRecall  <= 1'b1;
      recallStart <= 1'b0;
    end else begin
      recallStart <= launch;
      if (!resetSync)  needRecall <= 1'b1;
      else if (launch) needRecall <= 1'b0;
    end
  end

  always_comb begin
    strobe           = '0;
    strobe.loadTimer = launch;
  end

  assign storeInhibit = !switchSync;
  assign sramReady    = switchSync && !timerBusy;

  AST_RECALL_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |=> !recallStart); // R2
  AST_RECALL_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> !needRecall); // R5
  AST_DEEP_ARMS: assert property (@(posedge clk) disable iff (!rstN)
    !resetSync |=> needRecall); // R5
  AST_NO_SHALLOW_RECALL: assert property (@(posedge clk) disable iff (!rstN)
    (!needRecall && resetSync) |=> !recallStart); // R4
  AST_READY_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    sramReady |-> !storeInhibit); // R7

endmodule

// File: rtl/nvsram_power_seq.sv
module nvsram_power_seq
  import nvsram_power_seq_pkg::*;
#(
  parameter int HOLDOFF     = 2500,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic aboveSwitch,
  input  logic aboveReset,
  output logic recallStart,
  output logic storeInhibit,
  output logic sramReady,
  output logic holdoffBusy
);

  seqStrobe_t strobe;
  logic       switchSync;
  logic       resetSync;
  logic       timerBusy;

  nvsram_power_seq_dp #(
    .HOLDOFF    (HOLDOFF),
    .SYNC_STAGES(SYNC_STAGES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .aboveSwitch(aboveSwitch),
    .aboveReset (aboveReset),
    .strobe     (strobe),
    .switchSync (switchSync),
    .resetSync  (resetSync),
    .timerBusy  (timerBusy)
  );

  nvsram_power_seq_ctrl uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .switchSync  (switchSync),
    .resetSync   (resetSync),
    .timerBusy   (timerBusy),
    .strobe      (strobe),
    .recallStart (recallStart),
    .storeInhibit(storeInhibit),
    .sramReady   (sramReady)
  );

  assign holdoffBusy = timerBusy;

  AST_RECALL_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    recallStart |-> holdoffBusy); // R6
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    holdoffBusy |-> !sramReady); // R7

endmodule

// File: tb/nvsram_power_seq_test.sv
module nvsram_power_seq_test;

  localparam int HOLD = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic aboveSwitch = 1'b0;
  logic aboveReset = 1'b0;
  logic recallStart, storeInhibit, sramReady, holdoffBusy;

  int checks = 0;
  int errors = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  nvsram_power_seq #(.HOLDOFF(HOLD), .SYNC_STAGES(2)) uut (
    .clk(clk), .rstN(rstN), .aboveSwitch(aboveSwitch), .aboveReset(aboveReset),
    .recallStart(recallStart), .storeInhibit(storeInhibit),
    .sramReady(sramReady), .holdoffBusy(holdoffBusy)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // sw, rs, edges, expPulses, expInhibit, expReady, expBusy
  typedef struct packed {
    logic sw; logic rs; logic [7:0] edges; logic [3:0] pulses;
    logic inh; logic rdy; logic busy;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 8'd4, 4'd0, 1'b1, 1'b0, 1'b0},  // R3 supply low
    '{1'b1, 1'b1, 8'd3, 4'd1, 1'b0, 1'b0, 1'b1},  // R2 cold rise, recall
    '{1'b1, 1'b1, 8'd8, 4'd0, 1'b0, 1'b1, 1'b0},  // R6 hold-off ends
    '{1'b0, 1'b1, 8'd4, 4'd0, 1'b1, 1'b0, 1'b0},  // R4 shallow dip
    '{1'b1, 1'b1, 8'd4, 4'd0, 1'b0, 1'b1, 1'b0},  // R4 no recall
    '{1'b0, 1'b0, 8'd4, 4'd0, 1'b1, 1'b0, 1'b0},  // R5 deep dip
    '{1'b0, 1'b1, 8'd4, 4'd0, 1'b1, 1'b0, 1'b0},  // R5 partial recovery
    '{1'b1, 1'b1, 8'd3, 4'd1, 1'b0, 1'b0, 1'b1},  // R5 recall
    '{1'b1, 1'b1, 8'd8, 4'd0, 1'b0, 1'b1, 1'b0}   // R7 ready
  };

  task automatic stepEdges(input int n);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (recallStart) pulses++;
    end
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8 reset state, with inputs high during reset
    aboveSwitch = 1'b1; aboveReset = 1'b1;
    stepEdges(3);
    check("R8", "recallStart", recallStart, 0);
    check("R8", "storeInhibit", storeInhibit, 1);
    check("R8", "sramReady", sramReady, 0);
    check("R8", "holdoffBusy", holdoffBusy, 0);
    aboveSwitch = 1'b0; aboveReset = 1'b0;
    stepEdges(1);
    rstN = 1'b1;
    pulses = 0;

    for (int i = 0; i < NV; i++) begin
      aboveSwitch = VECS[i].sw;
      aboveReset  = VECS[i].rs;
      pulses = 0;
      stepEdges(int'(VECS[i].edges));
      check($sformatf("R2/R4/R5 vec%0d", i), "pulses", pulses, int'(VECS[i].pulses));
      check($sformatf("R3 vec%0d", i), "storeInhibit", storeInhibit, int'(VECS[i].inh));
      check($sformatf("R7 vec%0d", i), "sramReady", sramReady, int'(VECS[i].rdy));
      check($sformatf("R6 vec%0d", i), "holdoffBusy", holdoffBusy, int'(VECS[i].busy));
    end

    // R1: a change is visible only after two edges
    aboveSwitch = 1'b0;
    stepEdges(1);
    check("R1", "storeInhibit after 1 edge", storeInhibit, 0);
    stepEdges(1);
    check("R1", "storeInhibit after 2 edges", storeInhibit, 1);

    // R6: hold-off window length, deep dip then recovery
    aboveReset = 1'b0;
    stepEdges(4);
    aboveSwitch = 1'b1; aboveReset = 1'b1;
    pulses = 0;
    stepEdges(2);
    check("R6", "busy before launch", holdoffBusy, 0);
    stepEdges(1);
    check("R2", "recallStart high", recallStart, 1);
    check("R6", "busy at launch", holdoffBusy, 1);
    stepEdges(1);
    check("R2", "recallStart one cycle", recallStart, 0);
    stepEdges(HOLD - 2);
    check("R6", "busy last cycle", holdoffBusy, 1);
    check("R7", "not ready last busy cycle", sramReady, 0);
    stepEdges(1);
    check("R6", "busy ended", holdoffBusy, 0);
    check("R7", "ready after hold-off", sramReady, 1);
    check("R5", "single pulse", pulses, 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule